// File: doc/BRIEF.md
# Wrapping Display Address Generator

This block produces the byte address that a display fetch engine uses to read video memory for a bitmapped or character display. It keeps two registers. The row start register remembers where the current character row began. The running byte register walks across the scan line. At a programmable point on the final line of a frame, both registers take the screen base. During horizontal sync, the block either repeats the same character row or moves on to the next one. During the active region, it advances eight bytes per character cell.

The step phase depends on the column mode. In the 40-column mode, steps are half as frequent as in the normal mode. The byte address lives in a 32 KB window. When a step leaves the upper part of that window, the address does not roll over to zero. It is folded into a base region chosen for the current mode, and the offset below 2 KB is kept. The timing generator supplies the horizontal count, the sync flag, the last-line flag and the end-of-character-row flag. This block only computes addresses and does not access memory.

Top module: `disp_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears both the row start register and the byte address, so `addr` reads 0 afterwards.
- R2: When `h_count` equals the parameter H_RST_POS while `v_last` is high, both the row start register and the byte address take `screen_base` at the next edge. Any sync copy or step in the same cycle is applied after this load.
- R3: When `hsync` is high and `row_end` is high, the row start register takes the current byte address, and the byte address is left as it is.
- R4: When `hsync` is high and `row_end` is low, the byte address reloads from the row start register.
- R5: In the normal mode (`col40` low), inside the active region (`h_count` < H_ACTIVE), the byte address grows by 8 exactly when the low 3 bits of `h_count` are zero.
- R6: In the 40-column mode (`col40` high), inside the active region, the byte address grows by 8 only when the low 4 bits of `h_count` equal 8.
- R7: When `h_count` >= H_ACTIVE, no step happens, whatever the low bits of `h_count` are.
- R8: After a step, the sum is taken modulo 2^15. If bits 14 to 11 of the sum are all zero, the byte address becomes `mode_base` ORed with bits 10 to 0 of the sum.
- R9: Steps never change the row start register. Only the frame load (R2) and the end-of-row copy (R3) change it.
- R10: When a sync reload and a step fall in the same cycle, the step applies to the reloaded value, so the result is the row start plus 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the timing generator |
| rst | input | 1 | Synchronous active-high reset |
| h_count | input | HCNT_W | Horizontal position counter |
| hsync | input | 1 | Horizontal sync active |
| v_last | input | 1 | Current line is the last line of the frame |
| row_end | input | 1 | Current scan line is the final line of a character row |
| col40 | input | 1 | 40-column mode: step at half rate with a shifted phase |
| screen_base | input | ADDR_W | Address loaded at frame start |
| mode_base | input | ADDR_W | Region into which overflowing addresses fold |
| addr | output | ADDR_W | Current video byte address |

## Verification
Some checks run on every cycle. The bound checker confirms that the frame load delivers the screen base, that a plain step adds eight, and that nothing moves outside the active region or off the step phase. It also confirms that a folded address keeps its low offset and carries every mode-base bit.

Other behaviour shows up only across several cycles, because the row start register is not visible at the ports. This covers the end-of-row copy, the reload on sync, and the rule that steps leave the row start untouched. The bench shows these through later reloads. Its frame sweeps cover both column modes, several screen and mode bases, and repeated wraps, and compare every cycle against an arithmetic model.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  // Classification of what the step stage did in a cycle.
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_PLAIN = 2'd1,
    STEP_FOLD = 2'd2
  } step_kind_e;
endpackage

// File: rtl/dag_tick_decode.sv
module dag_tick_decode #(
  parameter int HCNT_W   = 10,
  parameter int H_ACTIVE = 640,
  parameter int STEP     = 8
) (
  input  logic [HCNT_W-1:0] h_count,
  input  logic              col40,
  output logic              in_active,
  output logic              tick
);
  localparam int PH_W = $clog2(STEP);
  localparam int HP_W = PH_W + 1;

  function automatic logic cell_edge(input logic [HP_W-1:0] low, input logic half_rate);
    if (half_rate) cell_edge = (low == HP_W'(STEP));
    else           cell_edge = (low[PH_W-1:0] == '0);
  endfunction

  assign in_active = (h_count < HCNT_W'(H_ACTIVE));
  assign tick      = in_active && cell_edge(h_count[HP_W-1:0], col40);
endmodule

// File: rtl/dag_addr_next.sv
module dag_addr_next
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int KEEP_W = 11,
  parameter int STEP   = 8
) (
  input  logic [ADDR_W-1:0] row_q,
  input  logic [ADDR_W-1:0] byte_q,
  input  logic              ld_frame,
  input  logic              hsync,
  input  logic              row_end,
  input  logic              tick,
  input  logic [ADDR_W-1:0] screen_base,
  input  logic [ADDR_W-1:0] mode_base,
  output logic [ADDR_W-1:0] row_d,
  output logic [ADDR_W-1:0] byte_d,
  output step_kind_e        kind
);
  localparam int TOP_W = ADDR_W - KEEP_W;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] a);
    bump = a + ADDR_W'(STEP);
  endfunction

  function automatic logic upper_empty(input logic [ADDR_W-1:0] a);
    upper_empty = (a[ADDR_W-1:KEEP_W] == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] fold(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base);
    fold = base | {{TOP_W{1'b0}}, a[KEEP_W-1:0]};
  endfunction

  logic [ADDR_W-1:0] row_s1, byte_s1, row_s2, byte_s2, stepped;

  always_comb begin
    // stage 1: frame load
    row_s1  = ld_frame ? screen_base : row_q;
    byte_s1 = ld_frame ? screen_base : byte_q;
    // stage 2: sync copy / reload
    row_s2  = row_s1;
    byte_s2 = byte_s1;
    if (hsync) begin
      if (row_end) row_s2  = byte_s1;
      else         byte_s2 = row_s1;
    end
    // stage 3: cell step with fold
    stepped = bump(byte_s2);
    kind    = STEP_NONE;
    byte_d  = byte_s2;
    if (tick) begin
      if (upper_empty(stepped)) begin
        byte_d = fold(stepped, mode_base);
        kind   = STEP_FOLD;
      end else begin
        byte_d = stepped;
        kind   = STEP_PLAIN;
      end
    end
    row_d = row_s2;
  end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int KEEP_W    = 11,
  parameter int STEP      = 8,
  parameter int HCNT_W    = 10,
  parameter int H_ACTIVE  = 640,
  parameter int H_RST_POS = 648
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HCNT_W-1:0] h_count,
  input  logic              hsync,
  input  logic              v_last,
  input  logic              row_end,
  input  logic              col40,
  input  logic [ADDR_W-1:0] screen_base,
  input  logic [ADDR_W-1:0] mode_base,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] row_q, byte_q, row_d, byte_d;
  logic              in_active, tick, ld_frame, wrap_hit;
  step_kind_e        kind;

  assign ld_frame = v_last && (h_count == HCNT_W'(H_RST_POS));

  dag_tick_decode #(.HCNT_W(HCNT_W), .H_ACTIVE(H_ACTIVE), .STEP(STEP)) u_tick (
    .h_count(h_count), .col40(col40), .in_active(in_active), .tick(tick)
  );

  dag_addr_next #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .STEP(STEP)) u_next (
    .row_q(row_q), .byte_q(byte_q), .ld_frame(ld_frame), .hsync(hsync),
    .row_end(row_end), .tick(tick), .screen_base(screen_base),
    .mode_base(mode_base), .row_d(row_d), .byte_d(byte_d), .kind(kind)
  );

  assign wrap_hit = (kind == STEP_FOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      byte_q <= '0;
    end else begin
      row_q  <= row_d;
      byte_q <= byte_d;
    end
  end

  assign addr = byte_q;
endmodule

// File: rtl/disp_addr_gen_chk.sv
module disp_addr_gen_chk #(
  parameter int ADDR_W   = 15,
  parameter int KEEP_W   = 11,
  parameter int STEP     = 8,
  parameter int HCNT_W   = 10,
  parameter int H_ACTIVE = 640
) (
  input logic              clk,
  input logic              rst,
  input logic [HCNT_W-1:0] h_count,
  input logic              hsync,
  input logic              col40,
  input logic [ADDR_W-1:0] screen_base,
  input logic [ADDR_W-1:0] mode_base,
  input logic [ADDR_W-1:0] addr,
  input logic              ld_frame,
  input logic              tick,
  input logic              wrap_hit
);
  localparam int PH_W = $clog2(STEP);
  localparam int HP_W = PH_W + 1;

  p_frame_load_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_frame && !hsync && !tick) |=> (addr == $past(screen_base)));

  p_plain_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld_frame && !hsync && tick && !wrap_hit) |=> (addr == $past(addr) + ADDR_W'(STEP)));

  p_col40_phase_r6: assert property (@(posedge clk) disable iff (rst)
    (col40 && tick) |-> (h_count[HP_W-1:0] == HP_W'(STEP)));

  p_no_step_outside_r7: assert property (@(posedge clk) disable iff (rst)
    (h_count >= HCNT_W'(H_ACTIVE)) |-> !tick);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!ld_frame && !hsync && !tick) |=> $stable(addr));

  p_fold_offset_r8: assert property (@(posedge clk) disable iff (rst)
    (!ld_frame && !hsync && tick && wrap_hit) |=>
      (addr[KEEP_W-1:0] == $past(addr[KEEP_W-1:0]) + KEEP_W'(STEP)));

  p_fold_base_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && wrap_hit) |=> ((addr & $past(mode_base)) == $past(mode_base)));
endmodule

bind disp_addr_gen disp_addr_gen_chk #(
  .ADDR_W(ADDR_W), .KEEP_W(KEEP_W), .STEP(STEP), .HCNT_W(HCNT_W), .H_ACTIVE(H_ACTIVE)
) u_chk (
  .clk(clk), .rst(rst), .h_count(h_count), .hsync(hsync), .col40(col40),
  .screen_base(screen_base), .mode_base(mode_base), .addr(addr),
  .ld_frame(ld_frame), .tick(tick), .wrap_hit(wrap_hit)
);

// File: tb/disp_addr_gen_tb.sv
module disp_addr_gen_tb_top;
  localparam int CLK_P   = 10;
  localparam int AW      = 15;
  localparam int HW      = 6;
  localparam int H_ACT   = 32;
  localparam int H_RST   = 40;
  localparam int H_TOT   = 48;
  localparam int LINES   = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [HW-1:0] h_count = '0;
  logic          hsync = 1'b0, v_last = 1'b0, row_end = 1'b0, col40 = 1'b0;
  logic [AW-1:0] screen_base = '0, mode_base = '0;
  logic [AW-1:0] addr;

  int n_chk = 0;
  int n_fail = 0;
  int m_row = 0;
  int m_byte = 0;

  disp_addr_gen #(.ADDR_W(AW), .KEEP_W(11), .STEP(8), .HCNT_W(HW),
                  .H_ACTIVE(H_ACT), .H_RST_POS(H_RST)) dut_i (
    .clk(clk), .rst(rst), .h_count(h_count), .hsync(hsync), .v_last(v_last),
    .row_end(row_end), .col40(col40), .screen_base(screen_base),
    .mode_base(mode_base), .addr(addr)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: addr=0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  // one clock with the given inputs; model updated arithmetically
  task automatic apply(input int h, input bit hs, input bit vl, input bit re,
                       input bit c40, input int sb, input int mb, input string tag);
    string t;
    bit stepped;
    @(negedge clk);
    h_count = HW'(h); hsync = hs; v_last = vl; row_end = re; col40 = c40;
    screen_base = AW'(sb); mode_base = AW'(mb);
    t = "R7";
    if (vl && h == H_RST) begin m_row = sb; m_byte = sb; t = "R2"; end
    if (hs) begin
      if (re) begin m_row = m_byte; t = "R3"; end
      else begin m_byte = m_row; t = "R4"; end
    end
    stepped = (h < H_ACT) && (c40 ? (h % 16 == 8) : (h % 8 == 0));
    if (stepped) begin
      m_byte = (m_byte + 8) % 32768;
      t = c40 ? "R6" : "R5";
      if (m_byte / 2048 == 0) begin m_byte = mb | (m_byte % 2048); t = "R8"; end
    end
    @(posedge clk); #1;
    check((tag == "") ? t : tag, int'(addr), m_byte);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: addr=0x%04h expected completion", addr);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1", int'(addr), 0);
    @(negedge clk); rst = 1'b0;

    // R2 frame load
    apply(H_RST, 0, 1, 0, 0, 'h1230, 'h3000, "R2");
    // R5 normal step and off-phase hold
    apply(0, 0, 0, 0, 0, 'h1230, 'h3000, "R5");
    apply(3, 0, 0, 0, 0, 'h1230, 'h3000, "R5");
    // R6 40-column phase
    apply(0, 0, 0, 0, 1, 'h1230, 'h3000, "R6");
    apply(8, 0, 0, 0, 1, 'h1230, 'h3000, "R6");
    apply(16, 0, 0, 0, 1, 'h1230, 'h3000, "R6");
    // R7 outside active region
    apply(32, 0, 0, 0, 0, 'h1230, 'h3000, "R7");
    apply(56, 0, 0, 0, 0, 'h1230, 'h3000, "R7");
    // R4 reload from row start
    apply(33, 1, 0, 0, 0, 'h1230, 'h3000, "R4");
    check("R4", int'(addr), 'h1230);
    // R9 steps leave row start alone
    apply(8, 0, 0, 0, 0, 'h1230, 'h3000, "R9");
    apply(16, 0, 0, 0, 0, 'h1230, 'h3000, "R9");
    apply(33, 1, 0, 0, 0, 'h1230, 'h3000, "R9");
    check("R9", int'(addr), 'h1230);
    // R3 end-of-row copy, shown by a later reload
    apply(0, 0, 0, 0, 0, 'h1230, 'h3000, "R3");
    apply(33, 1, 0, 1, 0, 'h1230, 'h3000, "R3");
    apply(8, 0, 0, 0, 0, 'h1230, 'h3000, "R3");
    apply(33, 1, 0, 0, 0, 'h1230, 'h3000, "R3");
    check("R3", int'(addr), 'h1238);
    // R8 fold at top of window and in low region
    apply(H_RST, 0, 1, 0, 0, 'h7FF8, 'h5800, "R2");
    apply(0, 0, 0, 0, 0, 'h7FF8, 'h5800, "R8");
    check("R8", int'(addr), 'h5800);
    apply(H_RST, 0, 1, 0, 0, 'h07F0, 'h3000, "R2");
    apply(0, 0, 0, 0, 0, 'h07F0, 'h3000, "R8");
    check("R8", int'(addr), 'h37F8);
    // R10 reload then step in one cycle
    apply(H_RST, 0, 1, 0, 0, 'h2000, 'h3000, "R2");
    apply(0, 0, 0, 0, 0, 'h2000, 'h3000, "R10");
    apply(8, 0, 0, 0, 0, 'h2000, 'h3000, "R10");
    apply(16, 1, 0, 0, 0, 'h2000, 'h3000, "R10");
    check("R10", int'(addr), 'h2008);

    // frame sweeps over both modes and several bases
    for (int f = 0; f < 8; f++) begin
      int sb;
      int mb;
      sb = (f < 4) ? ('h7FC0 + 8 * f) : ('h3000 + 'h400 * f);
      mb = (f % 3 == 0) ? 'h3000 : ((f % 3 == 1) ? 'h5800 : 'h4000);
      for (int ln = 0; ln < LINES; ln++) begin
        for (int h = 0; h < H_TOT; h++) begin
          apply(h, (h >= 36 && h < 40), (ln == LINES - 1), (ln % 4 == 3),
                f[0], sb, mb, "");
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule